// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a binary up-counter built from a chain of identical 4-bit stages. Every state bit in the chain updates on the same rising clock edge. Two synchronous controls can override counting. An active-low clear forces the count to zero, and it wins over everything else. An active-low parallel load copies a data word into the count. Counting needs two enables to be high together. The first is a shared "parallel" enable that reaches every stage. The second is a "trickle" enable that feeds forward through the carry chain.

Each stage produces a combinational carry. The carry is high while that stage holds all ones and its trickle enable is high. The carry drives the trickle enable of the next stage, so the whole chain counts as one wide binary counter with no added gating. The top-level carry lets users cascade further. To get a modulus shorter than the full range, decode the terminal count outside the block into an active-low signal on the clear input. The counter then returns to zero on the edge after it reaches that count.

The interface carries no data stream. All pins are plain level-sensitive controls and outputs, and none of them has a valid/ready handshake or back-pressure.

Top module: `sync_cascade_counter`

## Requirements
- R1: `count_q` changes only on a rising edge of `clk`. Changes on `clr_n`, `load_n`, `en_p`, `en_t` or `load_val` between edges leave `count_q` unchanged.
- R2: If `clr_n` is 0 at a rising edge, `count_q` becomes 0 whatever the values of `load_n`, `en_p` and `en_t`.
- R3: If `load_n` is 0 and `clr_n` is 1 at a rising edge, `count_q` becomes `load_val` whatever the values of `en_p` and `en_t`.
- R4: If `clr_n`, `load_n`, `en_p` and `en_t` are all 1 at a rising edge, `count_q` increases by one. If either enable is 0 and both overrides are 1, `count_q` holds its value.
- R5: If `clr_n` and `load_n` are both 0 at an edge, the clear wins and `count_q` becomes 0, not `load_val`.
- R6: `carry_out` is 1 exactly when `en_t` is 1 and `count_q` is all ones. It follows `en_t` combinationally, with no clock edge in between.
- R7: Incrementing from all ones wraps `count_q` to 0.
- R8: A 4-bit stage above the lowest one changes in a counting cycle only when all lower stages hold all ones. The chain as a whole behaves as one binary counter of width 4×`STAGES`.
- R9: If `clr_n` is driven low exactly when `count_q` equals M−1, the counter cycles through 0 to M−1 with modulus M.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state bits |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Parallel count enable, shared by all stages |
| en_t | input | 1 | Trickle count enable into the lowest stage; also gates the carry |
| load_val | input | 4×STAGES | Value taken by a load |
| count_q | output | 4×STAGES | Current count |
| carry_out | output | 1 | Combinational carry of the top stage, for further cascading |

## Verification
The count results are due one rising edge after their controls are sampled. The driver applies controls at a falling edge and queues the value the next edge must produce. The monitor pops that value a short time after the following rising edge and compares it. The carry output has no register on its path, so the bench checks it 1 ns after the driver changes the inputs, before any edge. The bench also compares `count_q` against the value expected before the edge, which shows that no mid-cycle change has leaked through.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  parameter int unsigned NIB_W = 4;

  typedef struct packed {
    logic clr_n;
    logic load_n;
    logic en_p;
  } ctl_t;

  typedef enum logic [1:0] {
    M_CLEAR = 2'd0,
    M_LOAD  = 2'd1,
    M_COUNT = 2'd2,
    M_HOLD  = 2'd3
  } mode_e;
endpackage

// File: rtl/cnt_next_logic.sv
module cnt_next_logic #(
  parameter int unsigned W = cnt_pkg::NIB_W
) (
  input  cnt_pkg::ctl_t ctl,
  input  logic          en_t,
  input  logic [W-1:0]  cur,
  input  logic [W-1:0]  din,
  output cnt_pkg::mode_e mode,
  output logic [W-1:0]  nxt
);
  always_comb begin
    if (!ctl.clr_n)                mode = cnt_pkg::M_CLEAR;
    else if (!ctl.load_n)          mode = cnt_pkg::M_LOAD;
    else if (ctl.en_p && en_t)     mode = cnt_pkg::M_COUNT;
    else                           mode = cnt_pkg::M_HOLD;
  end

  always_comb begin
    unique case (mode)
      cnt_pkg::M_CLEAR: nxt = '0;
      cnt_pkg::M_LOAD:  nxt = din;
      cnt_pkg::M_COUNT: nxt = cur + W'(1);
      default:          nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_carry_gate.sv
module cnt_carry_gate #(
  parameter int unsigned W = cnt_pkg::NIB_W
) (
  input  logic [W-1:0] cur,
  input  logic         en_t,
  output logic         rco
);
  logic full;
  assign full = &cur;
  assign rco  = full & en_t;
endmodule

// File: rtl/cnt_nibble_stage.sv
module cnt_nibble_stage #(
  parameter int unsigned W = cnt_pkg::NIB_W
) (
  input  logic          clk,
  input  cnt_pkg::ctl_t ctl,
  input  logic          en_t,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  q,
  output logic          rco
);
  logic [W-1:0]   nxt;
  cnt_pkg::mode_e mode;

  cnt_next_logic #(.W(W)) u_next (
    .ctl(ctl), .en_t(en_t), .cur(q), .din(din), .mode(mode), .nxt(nxt)
  );

  always_ff @(posedge clk) q <= nxt;

  cnt_carry_gate #(.W(W)) u_carry (.cur(q), .en_t(en_t), .rco(rco));

  // assertion support: properties are live only after the first clear
  logic seen_clr;
  always_ff @(posedge clk)
    if (!ctl.clr_n) seen_clr <= 1'b1;

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (seen_clr !== 1'b1)
    !ctl.clr_n |=> (q == '0));
  p_load_takes_r3: assert property (@(posedge clk) disable iff (seen_clr !== 1'b1)
    (ctl.clr_n && !ctl.load_n) |=> (q == $past(din)));
  p_hold_r4: assert property (@(posedge clk) disable iff (seen_clr !== 1'b1)
    (ctl.clr_n && ctl.load_n && !(ctl.en_p && en_t)) |=> $stable(q));
  p_incr_r4: assert property (@(posedge clk) disable iff (seen_clr !== 1'b1)
    (ctl.clr_n && ctl.load_n && ctl.en_p && en_t) |=> (q == W'($past(q) + W'(1))));
  p_wrap_r7: assert property (@(posedge clk) disable iff (seen_clr !== 1'b1)
    (ctl.clr_n && ctl.load_n && ctl.en_p && en_t && (&q)) |=> (q == '0));
endmodule

// File: rtl/sync_cascade_counter.sv
module sync_cascade_counter #(
  parameter int unsigned STAGES = 3,
  localparam int unsigned NW    = cnt_pkg::NIB_W,
  localparam int unsigned CW    = NW * STAGES
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic          en_p,
  input  logic          en_t,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count_q,
  output logic          carry_out
);
  cnt_pkg::ctl_t     ctl;
  logic [STAGES:0]   t_chain;

  assign ctl     = '{clr_n: clr_n, load_n: load_n, en_p: en_p};
  assign t_chain[0] = en_t;
  assign carry_out  = t_chain[STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cnt_nibble_stage #(.W(NW)) u_stage (
      .clk (clk),
      .ctl (ctl),
      .en_t(t_chain[k]),
      .din (load_val[k*NW +: NW]),
      .q   (count_q[k*NW +: NW]),
      .rco (t_chain[k+1])
    );
  end

  logic seen_clr;
  always_ff @(posedge clk)
    if (!clr_n) seen_clr <= 1'b1;

  for (genvar k = 1; k < STAGES; k++) begin : g_chk
    p_upper_hold_r8: assert property (@(posedge clk) disable iff (seen_clr !== 1'b1)
      (clr_n && load_n && !(&count_q[k*NW-1:0])) |=> $stable(count_q[k*NW +: NW]));
  end

  p_priority_r5: assert property (@(posedge clk) disable iff (seen_clr !== 1'b1)
    (!clr_n && !load_n) |=> (count_q == '0));
  p_carry_low_r6: assert property (@(posedge clk) disable iff (seen_clr !== 1'b1)
    !en_t |-> !carry_out);
endmodule

// File: tb/sync_cascade_counter_test.sv
`timescale 1ns/100ps
module sync_cascade_counter_test;
  localparam int unsigned STAGES = 3;
  localparam int unsigned CW = 4 * STAGES;
  localparam logic [CW-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [CW-1:0] load_val = '0;
  logic [CW-1:0] count_q;
  logic carry_out;

  always #2.5 clk = ~clk;

  sync_cascade_counter #(.STAGES(STAGES)) uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .load_val(load_val), .count_q(count_q), .carry_out(carry_out)
  );

  int checks = 0, fails = 0;
  logic [CW-1:0] model;
  logic [CW-1:0] exp_q[$];
  string tag_q[$];

  task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: apply controls at a falling edge, check combinational outputs, queue next state
  task automatic drive(logic c, logic l, logic p, logic t, logic [CW-1:0] v, string req);
    @(negedge clk);
    clr_n = c; load_n = l; en_p = p; en_t = t; load_val = v;
    #1;
    check({req, "/R1 pre-edge"}, count_q, model);
    check({req, "/R6 carry"}, CW'(carry_out), CW'(t && (model == ALL1)));
    if (!c)          model = '0;
    else if (!l)     model = v;
    else if (p && t) model = model + 1'b1;
    exp_q.push_back(model);
    tag_q.push_back(req);
  endtask

  // monitor: compare the result one edge later
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(tag_q.pop_front(), count_q, exp_q.pop_front());
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    model = '0;
    // reset state through clear (R2); the model is unknown before it, so skip pre-edge checks
    @(negedge clk); clr_n = 0; load_n = 1; en_p = 1; en_t = 1;
    @(posedge clk); #1; check("R2 reset clear", count_q, '0);
    check("R6 carry after clear", CW'(carry_out), '0);

    drive(1, 0, 0, 0, 12'h5A3, "R3 load no enables");
    drive(1, 1, 1, 1, '0, "R4 count");
    drive(1, 1, 0, 1, '0, "R4 hold en_p low");
    drive(1, 1, 1, 0, '0, "R4 hold en_t low");
    drive(0, 1, 1, 1, '0, "R2 clear with enables");
    drive(0, 0, 1, 1, 12'h777, "R5 clear beats load");
    drive(1, 0, 1, 1, 12'h0FE, "R3 load with enables");
    drive(1, 1, 1, 1, '0, "R8 count to 0FF");
    drive(1, 1, 1, 1, '0, "R8 cascade into 100");
    drive(1, 0, 0, 0, 12'h3FF, "R3 load 3FF");
    drive(1, 1, 1, 0, '0, "R8 en_t low blocks cascade");
    drive(1, 1, 1, 1, '0, "R8 cascade into 400");
    drive(1, 0, 0, 1, ALL1, "R3 load all ones");
    drive(1, 1, 0, 1, '0, "R6 carry at all ones");
    drive(1, 1, 0, 0, '0, "R6 carry gated by en_t");
    drive(1, 1, 1, 1, '0, "R7 wrap to zero");
    // R1: wiggle controls mid-cycle with no edge
    @(negedge clk); en_p = 1; en_t = 1; load_n = 0; load_val = 12'hABC; #1;
    check("R1 no change between edges", count_q, model);
    clr_n = 0; #0.5;
    check("R1 clear waits for edge", count_q, model);
    // R6: combinational carry tracks en_t with no edge
    drive(1, 0, 0, 0, ALL1, "R3 preload for R6");
    @(negedge clk); clr_n = 1; load_n = 1; en_p = 0; en_t = 0; #0.5;
    check("R6 carry low with en_t low", CW'(carry_out), '0);
    en_t = 1; #0.5;
    check("R6 carry follows en_t", CW'(carry_out), 1);
    en_t = 0;
    // R9: truncated modulus 10 via decoded clear
    drive(0, 1, 0, 0, '0, "R9 start at zero");
    for (int i = 0; i < 25; i++)
      drive((model == CW'(9)) ? 1'b0 : 1'b1, 1, 1, 1, '0, "R9 modulus 10");
    // long count through several cascades
    drive(1, 0, 0, 0, 12'hFF0, "R3 load FF0");
    for (int i = 0; i < 40; i++) drive(1, 1, 1, 1, '0, "R8 R7 long run");
    repeat (2) @(posedge clk);
    #2;
    finish_run();
  end
endmodule